// File: doc/BRIEF.md
# Local Bus Arbiter with Sticky CPU Request

This block decides which of three local requestors (video fetch, memory refresh and the CPU) drives a shared system bus. It also hands that bus to and takes it back from one external secondary master. The external master owns the bus whenever the synchronized grant line is low. The block asks for the bus by raising a single request line, which is the OR of every enabled local request. It may hand the bus to a local requestor only while grant is high. Among local requestors, video beats refresh and refresh beats the CPU. When video or refresh needs the bus while the CPU runs, the CPU clock is stopped at a CPU cycle boundary and the bus changes hands.

The CPU request is a flag that only the CPU can clear, by releasing the bus. The flag is set again by reset, by an unmasked interrupt, or by a completion signal from the external master. The external master signals completion as a short high-low-high pulse on grant. A grant that simply returns high, because video or refresh asked for the bus, does not count as completion. After reset the CPU flag is set and video and refresh are disabled. A configuration write enables either of them. With no enabled request, nobody owns the bus.

Top module: `bus_arb_top`

## Requirements
- R1: While reset is high, and on the first sampled cycle after it, all owner outputs are 0 and `req_out` is 0. With `grant_in` high, the CPU owns the bus two cycles after reset falls. Video and refresh are disabled by reset.
- R2: When video and refresh both request while the CPU can be preempted, video gets the bus first. Refresh follows when video drops its request.
- R3: `req_out` equals the OR of the CPU flag and the enabled video and refresh requests, delayed by one clock.
- R4: The CPU flag is cleared only by `cpu_release`, and it stays clear with no other stimulus. An `irq` pulse sets it. If `irq` and `cpu_release` come in the same cycle, the flag stays set.
- R5: The synchronized grant may go high, then low, then high again, with each of the two phases lasting fewer than `PULSE_MAX` cycles. This sets the CPU flag.
- R6: A grant that rises and stays high for `PULSE_MAX` cycles or more does not set the CPU flag.
- R7: A CPU owner is preempted by video or refresh only in a cycle where `cpu_cyc_end` is 1. `cpu_clk_en` is 1 only while `own_cpu` is 1.
- R8: No local owner is active while the synchronized grant is low. A pending local request is served only after `grant_in` returns high.
- R9: With no enabled request, all owner outputs and `req_out` are 0.
- R10: At most one owner output is 1 at a time. A video or refresh owner keeps the bus until its own request drops, even when a higher-priority request arrives.
- R11: A write with `cfg_vid_en`=0 makes `vid_req` have no effect on `own_vid` or `req_out`. `cfg_ref_en` does the same for `ref_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | CPU write strobe for the enable bits |
| cfg_vid_en | input | 1 | Video request enable written on `cfg_wr` |
| cfg_ref_en | input | 1 | Refresh request enable written on `cfg_wr` |
| cpu_release | input | 1 | CPU clears its request flag |
| irq | input | 1 | Unmasked interrupt, sets the CPU flag |
| cpu_cyc_end | input | 1 | CPU is at a point where its clock may be stopped |
| vid_req | input | 1 | Video bus request |
| ref_req | input | 1 | Refresh bus request |
| grant_in | input | 1 | Asynchronous grant from the external master, high = bus free to this side |
| req_out | output | 1 | Request to the external master |
| own_vid | output | 1 | Video owns the bus |
| own_ref | output | 1 | Refresh owns the bus |
| own_cpu | output | 1 | CPU owns the bus |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
Ownership is driven with:
- a single video request, first held off and then released by `cpu_cyc_end`, which separates a correct boundary wait from premature preemption;
- simultaneous video and refresh requests, then video re-requesting under a refresh owner, which separate strict priority from keeping the bus until the owner is done;
- grant held low with a video request pending, which shows whether the block waits for the external master.

On the grant line, a plain long return is contrasted with a short high-low-high pulse, which tells completion detection apart from a mere grant edge. Release and interrupt pulses, alone and together, show which one wins on the CPU flag.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_VID  = 2'd1,
    OWN_REF  = 2'd2,
    OWN_CPU  = 2'd3
  } owner_e;

  typedef enum logic [1:0] {
    DET_WAIT = 2'd0,
    DET_HIGH = 2'd1,
    DET_LOW  = 2'd2
  } det_e;
endpackage

// File: rtl/grant_sync.sv
module grant_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  // reset to 1: an idle external master leaves the bus free
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/grant_pulse_det.sv
module grant_pulse_det
  import bus_arb_pkg::*;
#(
  parameter int PULSE_MAX = 4,
  localparam int CW = $clog2(PULSE_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_s,
  output logic done_pulse
);
  det_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          rise, fall;

  assign rise = grant_s & ~prev_q;
  assign fall = ~grant_s & prev_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    done_pulse = 1'b0;
    unique case (st_q)
      DET_WAIT: begin
        if (rise) begin
          st_d  = DET_HIGH;
          cnt_d = '0;
        end
      end
      DET_HIGH: begin
        if (fall) begin
          st_d  = DET_LOW;
          cnt_d = '0;
        end else if (cnt_q == CW'(PULSE_MAX - 1)) begin
          st_d = DET_WAIT;    // plain return: grant stayed up
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      DET_LOW: begin
        if (rise) begin
          done_pulse = 1'b1;
          st_d       = DET_WAIT;
        end else if (cnt_q == CW'(PULSE_MAX - 1)) begin
          st_d = DET_WAIT;    // external master took the bus
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = DET_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= DET_WAIT;
      cnt_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      prev_q <= grant_s;
    end
  end
endmodule

// File: rtl/cpu_req_flag.sv
module cpu_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_irq,
  input  logic set_done,
  output logic req_q
);
  // setting wins so a return event is never lost
  always_ff @(posedge clk) begin
    if (rst)                       req_q <= 1'b1;
    else if (set_irq || set_done)  req_q <= 1'b1;
    else if (clr)                  req_q <= 1'b0;
  end
endmodule

// File: rtl/owner_sel.sv
module owner_sel
  import bus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic grant_s,
  input  logic v_req,
  input  logic r_req,
  input  logic c_req,
  input  logic cyc_end,
  output logic own_vid,
  output logic own_ref,
  output logic own_cpu,
  output logic clk_en
);
  owner_e cur_q, nxt;
  owner_e pick;

  always_comb begin
    if (!grant_s)   pick = OWN_NONE;
    else if (v_req) pick = OWN_VID;
    else if (r_req) pick = OWN_REF;
    else if (c_req) pick = OWN_CPU;
    else            pick = OWN_NONE;
  end

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      OWN_NONE: nxt = pick;
      OWN_VID:  nxt = (!grant_s) ? OWN_NONE : (v_req ? OWN_VID : pick);
      OWN_REF:  nxt = (!grant_s) ? OWN_NONE : (r_req ? OWN_REF : pick);
      OWN_CPU: begin
        if (!grant_s || !c_req)          nxt = OWN_NONE;
        else if ((v_req || r_req) && cyc_end) nxt = pick;
        else                             nxt = OWN_CPU;
      end
      default: nxt = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= OWN_NONE;
      own_vid <= 1'b0;
      own_ref <= 1'b0;
      own_cpu <= 1'b0;
      clk_en  <= 1'b0;
    end else begin
      cur_q   <= nxt;
      own_vid <= (nxt == OWN_VID);
      own_ref <= (nxt == OWN_REF);
      own_cpu <= (nxt == OWN_CPU);
      clk_en  <= (nxt == OWN_CPU);
    end
  end
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_MAX   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_vid_en,
  input  logic cfg_ref_en,
  input  logic cpu_release,
  input  logic irq,
  input  logic cpu_cyc_end,
  input  logic vid_req,
  input  logic ref_req,
  input  logic grant_in,
  output logic req_out,
  output logic own_vid,
  output logic own_ref,
  output logic own_cpu,
  output logic cpu_clk_en
);
  logic grant_sync;
  logic done_pulse;
  logic cpu_req_q;
  logic vid_en_q, ref_en_q;
  logic v_eff, r_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_en_q <= 1'b0;
      ref_en_q <= 1'b0;
    end else if (cfg_wr) begin
      vid_en_q <= cfg_vid_en;
      ref_en_q <= cfg_ref_en;
    end
  end

  assign v_eff = vid_req & vid_en_q;
  assign r_eff = ref_req & ref_en_q;

  always_ff @(posedge clk) begin
    if (rst) req_out <= 1'b0;
    else     req_out <= v_eff | r_eff | cpu_req_q;
  end

  grant_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(grant_in), .sync_out(grant_sync)
  );

  grant_pulse_det #(.PULSE_MAX(PULSE_MAX)) u_det (
    .clk(clk), .rst(rst), .grant_s(grant_sync), .done_pulse(done_pulse)
  );

  cpu_req_flag u_flag (
    .clk(clk), .rst(rst), .clr(cpu_release), .set_irq(irq),
    .set_done(done_pulse), .req_q(cpu_req_q)
  );

  owner_sel u_own (
    .clk(clk), .rst(rst), .grant_s(grant_sync), .v_req(v_eff),
    .r_req(r_eff), .c_req(cpu_req_q), .cyc_end(cpu_cyc_end),
    .own_vid(own_vid), .own_ref(own_ref), .own_cpu(own_cpu),
    .clk_en(cpu_clk_en)
  );
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk (
  input logic clk,
  input logic rst,
  input logic own_vid,
  input logic own_ref,
  input logic own_cpu,
  input logic cpu_clk_en,
  input logic cpu_cyc_end,
  input logic cpu_release,
  input logic vid_req,
  input logic vid_en_q,
  input logic grant_sync,
  input logic cpu_req_q
);
  AST_ONEHOT_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({own_vid, own_ref, own_cpu})); // R10

  AST_OWNER_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (own_vid || own_ref || own_cpu) |-> $past(grant_sync)); // R8

  AST_PREEMPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ($past(own_cpu) && (own_vid || own_ref)) |-> $past(cpu_cyc_end)); // R7

  AST_CLKEN_ONLY_OWNER: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> ($past(grant_sync) && $past(cpu_req_q))); // R7

  AST_FLAG_CLEARED_BY_CPU: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_req_q) |-> $past(cpu_release)); // R4

  AST_VID_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
    ($past(own_vid) && $past(vid_req) && $past(vid_en_q) && $past(grant_sync))
      |-> own_vid); // R10
endmodule

bind bus_arb_top bus_arb_chk u_chk (
  .clk(clk), .rst(rst), .own_vid(own_vid), .own_ref(own_ref),
  .own_cpu(own_cpu), .cpu_clk_en(cpu_clk_en), .cpu_cyc_end(cpu_cyc_end),
  .cpu_release(cpu_release), .vid_req(vid_req), .vid_en_q(vid_en_q),
  .grant_sync(grant_sync), .cpu_req_q(cpu_req_q)
);

// File: tb/tb_bus_arb_top.sv
module tb_bus_arb_top;
  logic clk = 1'b0;
  logic rst, cfg_wr, cfg_vid_en, cfg_ref_en, cpu_release, irq, cpu_cyc_end;
  logic vid_req, ref_req, grant_in;
  logic req_out, own_vid, own_ref, own_cpu, cpu_clk_en;
  int   n_chk = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  bus_arb_top dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_vid_en(cfg_vid_en),
    .cfg_ref_en(cfg_ref_en), .cpu_release(cpu_release), .irq(irq),
    .cpu_cyc_end(cpu_cyc_end), .vid_req(vid_req), .ref_req(ref_req),
    .grant_in(grant_in), .req_out(req_out), .own_vid(own_vid),
    .own_ref(own_ref), .own_cpu(own_cpu), .cpu_clk_en(cpu_clk_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {req_out,vid,ref,cpu,clk_en} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {req_out, own_vid, own_ref, own_cpu, cpu_clk_en};
  endfunction

  task automatic pulse_release();
    cpu_release = 1'b1; tick(1); cpu_release = 1'b0;
  endtask

  task automatic write_cfg(input logic v, input logic r);
    cfg_vid_en = v; cfg_ref_en = r; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(3);
    chk("R1 in reset", outs(), 5'b00000);
    vid_req = 1'b1;
    @(negedge clk) rst = 1'b0;
    tick(2);
    chk("R1 cpu owns after reset, R11 video disabled", outs(), 5'b10011);
    vid_req = 1'b0;
  endtask

  task automatic t_preempt();
    write_cfg(1'b1, 1'b1);
    vid_req = 1'b1; tick(4);
    chk("R7 no preempt without cyc_end", outs(), 5'b10011);
    cpu_cyc_end = 1'b1; tick(1); cpu_cyc_end = 1'b0;
    chk("R7 video preempts at boundary, clock stopped", outs(), 5'b11000);
    vid_req = 1'b0; tick(2);
    chk("R7 cpu resumes", outs(), 5'b10011);
  endtask

  task automatic t_priority();
    cpu_cyc_end = 1'b1; vid_req = 1'b1; ref_req = 1'b1; tick(2);
    chk("R2 video first", outs(), 5'b11000);
    vid_req = 1'b0; tick(2);
    chk("R2 refresh next", outs(), 5'b10100);
    vid_req = 1'b1; tick(3);
    chk("R10 refresh keeps bus", outs(), 5'b10100);
    ref_req = 1'b0; tick(2);
    chk("R10 video after refresh done", outs(), 5'b11000);
    vid_req = 1'b0; tick(2); cpu_cyc_end = 1'b0;
    chk("R2 back to cpu", outs(), 5'b10011);
  endtask

  task automatic t_release();
    pulse_release(); tick(2);
    chk("R9 idle with no request", outs(), 5'b00000);
    tick(8);
    chk("R4 flag stays clear", outs(), 5'b00000);
    ref_req = 1'b1; tick(1);
    chk("R3 req_out follows refresh", req_out, 1'b1);
    tick(1);
    chk("R3 refresh owns", outs(), 5'b10100);
    ref_req = 1'b0; tick(2);
    chk("R3 req_out drops", outs(), 5'b00000);
  endtask

  task automatic t_external();
    grant_in = 1'b0; tick(4);
    vid_req = 1'b1; tick(6);
    chk("R8 wait for grant", outs(), 5'b10000);
    grant_in = 1'b1; tick(4);
    chk("R8 video served after grant", outs(), 5'b11000);
    vid_req = 1'b0; tick(10);
    chk("R6 plain return does not set cpu flag", outs(), 5'b00000);
  endtask

  task automatic t_pulse();
    grant_in = 1'b0; tick(5);
    grant_in = 1'b1; tick(2);
    grant_in = 1'b0; tick(2);
    grant_in = 1'b1; tick(6);
    chk("R5 done pulse returns cpu", outs(), 5'b10011);
  endtask

  task automatic t_irq();
    pulse_release(); tick(3);
    chk("R4 released", outs(), 5'b00000);
    irq = 1'b1; tick(1); irq = 1'b0; tick(3);
    chk("R4 irq sets flag", outs(), 5'b10011);
    irq = 1'b1; cpu_release = 1'b1; tick(1);
    irq = 1'b0; cpu_release = 1'b0; tick(3);
    chk("R4 set wins over release", outs(), 5'b10011);
  endtask

  task automatic t_disable();
    write_cfg(1'b0, 1'b1);
    vid_req = 1'b1; cpu_cyc_end = 1'b1; tick(4);
    chk("R11 disabled video ignored", outs(), 5'b10011);
    pulse_release(); tick(3);
    chk("R11 disabled video not in req_out", outs(), 5'b00000);
    vid_req = 1'b0; cpu_cyc_end = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_vid_en = 1'b0; cfg_ref_en = 1'b0;
    cpu_release = 1'b0; irq = 1'b0; cpu_cyc_end = 1'b0;
    vid_req = 1'b0; ref_req = 1'b0; grant_in = 1'b1;
    t_reset();
    t_preempt();
    t_priority();
    t_release();
    t_external();
    t_pulse();
    t_irq();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule